// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Source Select

This stage sits in a single system-clock domain and turns one of ten per-cycle enable strobes into a slower output enable. Each input source is a one-cycle-wide strobe rather than a true clock. A control word chooses the source and enables the stage. A divisor word holds an integer part and a fractional part. The output carries one strobe per output period. The average ratio is the integer part plus the fraction divided by 2^FRAC_W.

The ten source codes are fixed. Code 0 is ground. Code 1 is the main oscillator strobe. Codes 2 and 3 are the two debug taps that every instance has. Codes 4 to 9 are lanes specific to the instance, and the parameter POP_MASK marks which of them are populated. Any unpopulated lane, and any code from 10 to 15, acts as ground.

A fractional accumulator stretches some periods by one source strobe, so the long-run ratio matches the programmed value. New settings are held in shadow registers. They only reach the counting logic at a period boundary, or while no period is running.

The controller is a three-state machine:
- **OFF**: the enable bit is clear. The counter and accumulator are held at zero, and the active settings track the shadow registers.
- **COUNT**: the stage counts strobes from the selected source.
- **HOLD**: the stage is enabled, but the settings select a dead source or an integer part of zero.

The transitions are:
- OFF→COUNT (*start*): enabled with live settings.
- OFF→HOLD (*park*): enabled with dead settings.
- COUNT→HOLD (*stall*): at a boundary, the shadow settings are dead.
- HOLD→COUNT (*resume*): the shadow settings become live.
- COUNT/HOLD→OFF (*stop*): the enable bit is cleared.

Top module: `csel_fracdiv`

## Requirements
- R1: After reset the output is low, the enable bit is clear and the source is 0. No strobe on any input produces an output pulse until the stage is configured.
- R2: Source code 0, and codes 10 to 15, produce no output pulse whatever the inputs do.
- R3: Code 1 selects `osc_stb`, code 2 selects `dbg_stb[0]` and code 3 selects `dbg_stb[1]`. Strobes on unselected inputs have no effect on the output.
- R4: Code 4+k selects `inst_stb[k]` when `POP_MASK[k]` is 1. With the default mask 6'b001111, codes 8 and 9 are unpopulated and behave as ground.
- R5: With fraction 0 and integer part N ≥ 1, the output pulses once for every N selected strobes, on the Nth. With N = 1 every selected strobe is passed through.
- R6: Each output period starts with an accumulator step: the fraction is added to a FRAC_W-bit accumulator, and a carry lengthens the next period to integer+1 strobes. The first period after a start has exactly integer strobes, with the accumulator at 0.
- R7: An integer part of 0 produces no output pulses.
- R8: Clearing the enable bit (control bit 4) silences the output from the next cycle and zeroes the strobe counter and the accumulator. After re-enabling, counting restarts from the first period.
- R9: A write to the source or the divisor during a running period does not affect that period. The new values apply from the next period.
- R10: An output pulse is high for one cycle, in the cycle after the clock edge that sampled the selected strobe which completed the period.
- R11: Register port: `cfg_sel`=0 writes control (bits [3:0] source, bit 4 enable); `cfg_sel`=1 writes divisor (bits [FRAC_W-1:0] fraction, bits [FRAC_W+INT_W-1:FRAC_W] integer). Writes land on the edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = divisor word |
| cfg_wdata | input | DATA_W | Write data |
| osc_stb | input | 1 | Main oscillator strobe (source 1) |
| dbg_stb | input | 2 | Debug tap strobes (sources 2, 3) |
| inst_stb | input | 6 | Instance-specific strobes (sources 4 to 9) |
| div_en_out | output | 1 | Divided output enable, one-cycle pulses |

## Verification
Some properties are checked on every cycle:
- dead source codes and unpopulated lanes never yield a selected strobe;
- every output pulse follows a selected strobe;
- the output is silent in HOLD and when the enable bit is clear;
- the strobe counter stays below the period length;
- the active settings never change inside a running period.

Other behaviour only the bench scenarios can show:
- the exact pulse counts for integer and fractional ratios;
- the stretch pattern of the accumulator;
- counting restarting from the first period after re-enable;
- an old period finishing on its old source and ratio after a mid-period write.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } div_state_e;

    localparam int SRC_W      = 4;
    localparam int FIRST_INST = 4;
    localparam int NUM_INST   = 6;
    localparam int NUM_SRC    = FIRST_INST + NUM_INST;

    // True when a source code maps to a lane that can carry strobes.
    function automatic logic src_live(input logic [SRC_W-1:0] code,
                                      input logic [NUM_INST-1:0] mask);
        logic ok;
        ok = 1'b0;
        if (code >= 4'd1 && code <= 4'd3) begin
            ok = 1'b1;
        end else begin
            for (int k = 0; k < NUM_INST; k++) begin
                if (int'(code) == FIRST_INST + k) ok = mask[k];
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/csel_src_mux.sv
module csel_src_mux
    import csel_pkg::*;
#(
    parameter logic [NUM_INST-1:0] POP_MASK = 6'b001111
) (
    input  logic [SRC_W-1:0]    sel,
    input  logic                osc_stb,
    input  logic [1:0]          dbg_stb,
    input  logic [NUM_INST-1:0] inst_stb,
    output logic                sel_stb
);
    localparam int LANES = 1 << SRC_W;
    localparam int SPARE = LANES - NUM_SRC;

    logic [NUM_INST-1:0] inst_gated;
    logic [LANES-1:0]    lanes;

    // Unpopulated lanes are tied to ground at elaboration.
    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_lane
        if (POP_MASK[gi]) begin : g_pop
            assign inst_gated[gi] = inst_stb[gi];
        end else begin : g_tie
            assign inst_gated[gi] = 1'b0;
        end
    end

    assign lanes   = {{SPARE{1'b0}}, inst_gated, dbg_stb, osc_stb, 1'b0};
    assign sel_stb = lanes[sel];

endmodule

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
    import csel_pkg::*;
#(
    parameter int INT_W  = 4,
    parameter int FRAC_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [SRC_W-1:0]  sh_src,
    output logic              sh_en,
    output logic [INT_W-1:0]  sh_int,
    output logic [FRAC_W-1:0] sh_frac
);
    localparam int EN_BIT = SRC_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_src  <= '0;
            sh_en   <= 1'b0;
            sh_int  <= '0;
            sh_frac <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                sh_src <= cfg_wdata[SRC_W-1:0];
                sh_en  <= cfg_wdata[EN_BIT];
            end else begin
                sh_frac <= cfg_wdata[FRAC_W-1:0];
                sh_int  <= cfg_wdata[FRAC_W +: INT_W];
            end
        end
    end

endmodule

// File: rtl/csel_frac_step.sv
module csel_frac_step #(
    parameter int INT_W  = 4,
    parameter int FRAC_W = 4
) (
    input  logic [FRAC_W-1:0] acc,
    input  logic [FRAC_W-1:0] frac,
    input  logic [INT_W-1:0]  int_part,
    output logic [FRAC_W-1:0] acc_nxt,
    output logic [INT_W:0]    len_nxt
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc} + {1'b0, frac};
        acc_nxt = sum[FRAC_W-1:0];
        len_nxt = {1'b0, int_part} + {{INT_W{1'b0}}, sum[FRAC_W]};
    end

endmodule

// File: rtl/csel_div_fsm.sv
module csel_div_fsm
    import csel_pkg::*;
#(
    parameter int                  INT_W    = 4,
    parameter int                  FRAC_W   = 4,
    parameter logic [NUM_INST-1:0] POP_MASK = 6'b001111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  sh_src,
    input  logic              sh_en,
    input  logic [INT_W-1:0]  sh_int,
    input  logic [FRAC_W-1:0] sh_frac,
    input  logic              sel_stb,
    input  logic [FRAC_W-1:0] acc_nxt,
    input  logic [INT_W:0]    len_nxt,
    output logic [SRC_W-1:0]  act_src,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic [FRAC_W-1:0] acc,
    output logic [INT_W:0]    cnt,
    output logic [INT_W:0]    len,
    output div_state_e        state,
    output logic              div_en_out
);
    div_state_e state_nxt;
    logic       live_sh;
    logic       boundary;

    assign live_sh  = src_live(sh_src, POP_MASK) && (sh_int != '0);
    assign boundary = sel_stb && (cnt == len - 1'b1);

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (sh_en) state_nxt = live_sh ? ST_COUNT : ST_HOLD;
            end
            ST_COUNT: begin
                if (!sh_en)                    state_nxt = ST_OFF;
                else if (boundary && !live_sh) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (!sh_en)       state_nxt = ST_OFF;
                else if (live_sh) state_nxt = ST_COUNT;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // Counter, accumulator and active settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_src  <= '0;
            act_int  <= '0;
            act_frac <= '0;
            acc      <= '0;
            cnt      <= '0;
            len      <= '0;
        end else begin
            case (state)
                ST_COUNT: begin
                    if (!sh_en) begin
                        cnt <= '0;
                        acc <= '0;
                    end else if (boundary) begin
                        act_src  <= sh_src;
                        act_int  <= sh_int;
                        act_frac <= sh_frac;
                        cnt      <= '0;
                        acc      <= acc_nxt;
                        len      <= len_nxt;
                    end else if (sel_stb) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    act_src  <= sh_src;
                    act_int  <= sh_int;
                    act_frac <= sh_frac;
                    cnt      <= '0;
                    acc      <= '0;
                    len      <= {1'b0, sh_int};
                end
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) div_en_out <= 1'b0;
        else        div_en_out <= (state == ST_COUNT) && sh_en && boundary;
    end

endmodule

// File: rtl/csel_fracdiv.sv
module csel_fracdiv
    import csel_pkg::*;
#(
    parameter int                  INT_W    = 4,
    parameter int                  FRAC_W   = 4,
    parameter int                  DATA_W   = 16,
    parameter logic [NUM_INST-1:0] POP_MASK = 6'b001111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                osc_stb,
    input  logic [1:0]          dbg_stb,
    input  logic [NUM_INST-1:0] inst_stb,
    output logic                div_en_out
);
    localparam int LEN_W = INT_W + 1;

    logic [SRC_W-1:0]  sh_src;
    logic              sh_en;
    logic [INT_W-1:0]  sh_int;
    logic [FRAC_W-1:0] sh_frac;
    logic [SRC_W-1:0]  act_src;
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] acc_nxt;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  len_nxt;
    logic              sel_stb;
    div_state_e        fsm_state;

    csel_cfg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .sh_src    (sh_src),
        .sh_en     (sh_en),
        .sh_int    (sh_int),
        .sh_frac   (sh_frac)
    );

    csel_src_mux #(.POP_MASK(POP_MASK)) u_mux (
        .sel      (act_src),
        .osc_stb  (osc_stb),
        .dbg_stb  (dbg_stb),
        .inst_stb (inst_stb),
        .sel_stb  (sel_stb)
    );

    csel_frac_step #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_step (
        .acc      (acc),
        .frac     (sh_frac),
        .int_part (sh_int),
        .acc_nxt  (acc_nxt),
        .len_nxt  (len_nxt)
    );

    csel_div_fsm #(.INT_W(INT_W), .FRAC_W(FRAC_W), .POP_MASK(POP_MASK)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sh_src     (sh_src),
        .sh_en      (sh_en),
        .sh_int     (sh_int),
        .sh_frac    (sh_frac),
        .sel_stb    (sel_stb),
        .acc_nxt    (acc_nxt),
        .len_nxt    (len_nxt),
        .act_src    (act_src),
        .act_int    (act_int),
        .act_frac   (act_frac),
        .acc        (acc),
        .cnt        (cnt),
        .len        (len),
        .state      (fsm_state),
        .div_en_out (div_en_out)
    );

endmodule

// File: rtl/csel_fracdiv_chk.sv
module csel_fracdiv_chk
    import csel_pkg::*;
#(
    parameter int                  INT_W    = 4,
    parameter int                  FRAC_W   = 4,
    parameter logic [NUM_INST-1:0] POP_MASK = 6'b001111
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_stb,
    input logic [SRC_W-1:0]  act_src,
    input logic [INT_W-1:0]  act_int,
    input logic [FRAC_W-1:0] act_frac,
    input logic [INT_W:0]    cnt,
    input logic [INT_W:0]    len,
    input logic [1:0]        state_q,
    input logic              sh_en,
    input logic              div_en_out
);
    // R2: ground code and the codes above 9 never yield a selected strobe.
    p_ground_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_src == 4'd0 || act_src > 4'd9) |-> !sel_stb);

    // R4: unpopulated lanes behave as ground.
    p_dead_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !src_live(act_src, POP_MASK) |-> !sel_stb);

    // R5: the strobe counter stays inside the period.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt < len));

    // R7: no pulse comes out of HOLD.
    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !div_en_out);

    // R8: a clear enable bit silences the next cycle.
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |=> !div_en_out);

    // R9: active settings only move at a period boundary.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && $past(state_q) == ST_COUNT && !div_en_out)
        |-> ($stable(act_src) && $stable(act_int) && $stable(act_frac)));

    // R10: every pulse follows a selected strobe.
    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_en_out |-> $past(sel_stb));

endmodule

bind csel_fracdiv csel_fracdiv_chk #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .POP_MASK(POP_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_stb    (sel_stb),
    .act_src    (act_src),
    .act_int    (act_int),
    .act_frac   (act_frac),
    .cnt        (cnt),
    .len        (len),
    .state_q    (fsm_state),
    .sh_en      (sh_en),
    .div_en_out (div_en_out)
);

// File: tb/tb_csel_fracdiv.sv
module tb_csel_fracdiv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        osc_stb = 1'b0;
    logic [1:0]  dbg_stb = '0;
    logic [5:0]  inst_stb = '0;
    logic        div_en_out;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;

    csel_fracdiv dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .osc_stb(osc_stb), .dbg_stb(dbg_stb),
        .inst_stb(inst_stb), .div_en_out(div_en_out)
    );

    always @(negedge clk) if (div_en_out) pulses++;

    // Fields: src, drive line (15 = all), integer, fraction, strobes, expected pulses.
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {4'd1,  4'd1,  4'd1,  4'd0,  8'd8,  8'd8},  // R3 osc pass-through
        {4'd2,  4'd2,  4'd1,  4'd0,  8'd5,  8'd5},  // R3 debug tap 0
        {4'd3,  4'd3,  4'd3,  4'd0,  8'd9,  8'd3},  // R5 divide by 3 on tap 1
        {4'd3,  4'd1,  4'd1,  4'd0,  8'd6,  8'd0},  // R3 other source ignored
        {4'd0,  4'd15, 4'd1,  4'd0,  8'd6,  8'd0},  // R2 ground
        {4'd12, 4'd15, 4'd1,  4'd0,  8'd6,  8'd0},  // R2 code above 9
        {4'd9,  4'd15, 4'd1,  4'd0,  8'd6,  8'd0},  // R4 unpopulated lane
        {4'd5,  4'd5,  4'd2,  4'd0,  8'd8,  8'd4},  // R4 populated lane
        {4'd1,  4'd1,  4'd2,  4'd8,  8'd10, 8'd4},  // R6 ratio 2.5
        {4'd1,  4'd1,  4'd1,  4'd4,  8'd10, 8'd8},  // R6 ratio 1.25
        {4'd1,  4'd1,  4'd0,  4'd5,  8'd6,  8'd0},  // R7 integer zero
        {4'd4,  4'd4,  4'd4,  4'd0,  8'd8,  8'd2},  // R5 divide by 4
        {4'd1,  4'd1,  4'd15, 4'd15, 8'd40, 8'd2}   // R6 maximum ratio
    };
    localparam string VEC_REQ [NV] = '{
        "R3", "R3", "R5", "R3", "R2", "R2", "R4", "R4", "R6", "R6", "R7", "R5", "R6"
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R11 word layout: control {en, src[3:0]}, divisor {int, frac}.
    task automatic setup(input int src, input bit en, input int ip, input int fp);
        wr(1'b0, 16'h0000);
        wr(1'b1, {8'd0, ip[3:0], fp[3:0]});
        wr(1'b0, {11'd0, en, src[3:0]});
        @(negedge clk);
        @(negedge clk);
        pulses = 0;
    endtask

    task automatic drive(input int line, input logic v);
        if (line == 15) begin
            osc_stb = v; dbg_stb = {2{v}}; inst_stb = {6{v}};
        end else if (line == 1) osc_stb = v;
        else if (line == 2 || line == 3) dbg_stb[line-2] = v;
        else if (line >= 4 && line <= 9) inst_stb[line-4] = v;
    endtask

    task automatic strobe(input int line, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); drive(line, 1'b1);
            @(negedge clk); drive(line, 1'b0);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and inert default configuration
        check("R1 out after reset", int'(div_en_out), 0);
        pulses = 0;
        strobe(15, 4);
        check("R1 no pulse before configuration", pulses, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            setup(int'(VEC[i][31:28]), 1'b1, int'(VEC[i][23:20]), int'(VEC[i][19:16]));
            strobe(int'(VEC[i][27:24]), int'(VEC[i][15:8]));
            check(VEC_REQ[i], pulses, int'(VEC[i][7:0]));
        end

        // R10: pulse one cycle after the strobe edge, one cycle wide
        setup(2, 1'b1, 1, 0);
        @(negedge clk); drive(2, 1'b1);
        @(negedge clk); drive(2, 1'b0);
        check("R10 pulse after strobe", int'(div_en_out), 1);
        @(negedge clk);
        check("R10 pulse width", int'(div_en_out), 0);

        // R8: disable resets counting
        setup(1, 1'b1, 3, 0);
        strobe(1, 2);
        wr(1'b0, {11'd0, 1'b0, 4'd1});
        strobe(1, 3);
        check("R8 silent while disabled", pulses, 0);
        wr(1'b0, {11'd0, 1'b1, 4'd1});
        @(negedge clk); @(negedge clk);
        strobe(1, 2);
        check("R8 count restarted", pulses, 0);
        strobe(1, 1);
        check("R8 first period after re-enable", pulses, 1);

        // R8: fraction accumulator restarts too (ratio 2.5 gives 2 then 2)
        setup(1, 1'b1, 2, 8);
        strobe(1, 3);
        wr(1'b0, {11'd0, 1'b0, 4'd1});
        wr(1'b0, {11'd0, 1'b1, 4'd1});
        @(negedge clk); @(negedge clk);
        pulses = 0;
        strobe(1, 4);
        check("R8 accumulator restarted", pulses, 2);

        // R9: divisor write mid-period
        setup(1, 1'b1, 4, 0);
        strobe(1, 1);
        wr(1'b1, {8'd0, 4'd1, 4'd0});
        strobe(1, 2);
        check("R9 old ratio kept", pulses, 0);
        strobe(1, 1);
        check("R9 old period completes", pulses, 1);
        strobe(1, 3);
        check("R9 new ratio applied", pulses, 4);

        // R9: source write mid-period
        setup(1, 1'b1, 2, 0);
        strobe(1, 1);
        wr(1'b0, {11'd0, 1'b1, 4'd2});
        strobe(1, 1);
        check("R9 old source finishes period", pulses, 1);
        strobe(1, 2);
        check("R9 old source dropped", pulses, 1);
        strobe(2, 2);
        check("R9 new source used", pulses, 2);

        // R7: integer zero written while running parks after the boundary
        setup(1, 1'b1, 1, 0);
        wr(1'b1, 16'h0000);
        strobe(1, 1);
        pulses = 0;
        strobe(1, 4);
        check("R7 zero integer silences", pulses, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule